// File: doc/BRIEF.md
# LLR Reliability Freeze Unit

This block sits beside the bit-LLR store of one processing element in a layered LDPC decoder. Each time the element rewrites an LLR, the block compares the fresh value with the word still held in the store, which is the value from the previous iteration. When the sign has not changed, the magnitude has not shrunk and the magnitude has reached a programmable share of the largest representable magnitude, the LLR is declared reliable. From then on it is frozen: its frozen bit is set, a single reserved stop code goes out in place of its normal message, and later local updates to it are dropped.

The stop code is the most negative two's-complement value of the message width. With 9-bit messages, data lies in -255..+255 and -256 means stop. Stop codes that arrive from other elements freeze the local copy of the LLR and are passed on once. A second, looser threshold marks ordinary outgoing messages as expendable when the pre- and post-processing values of the same update pass the same three tests. Thresholds are written as fixed-point fractions. The limit magnitude is computed once, when the fraction is written.

Top module: `llr_freeze_unit`

## Requirements
- R1: After reset, msg_valid is 0, every frozen bit reads 0 and every stored LLR reads 0.
- R2: Writing thr_frac with thr_sel=0 (hard) or thr_sel=1 (soft) sets that limit to floor(thr_frac*255/256). The reset fractions are 51 (hard limit 50) and 26 (soft limit 25).
- R3: A local update with upd_hard=1 to an unfrozen LLR freezes it when three tests all hold: new and stored values have the same sign (zero counts as positive), |new| >= |stored|, and |new| >= hard limit. On the next cycle msg_valid=1 and msg_data=-256 (stop). The frozen bit is set and the store takes the new value.
- R4: A local update to an unfrozen LLR that is not frozen (any test fails, or upd_hard=0) writes the new value and outputs it as msg_data on the next cycle.
- R5: A local update to a frozen LLR changes neither the stored value nor the output (msg_valid=0 next cycle).
- R6: A network stop code for an LLR whose frozen bit is clear sets the bit and forwards one stop message on the next cycle. The stored value is left unchanged.
- R7: A network stop code for an already frozen LLR produces no message.
- R8: A network data value for an unfrozen LLR is written to the store without producing a message. For a frozen LLR it is ignored.
- R9: msg_expendable is 1 on an ordinary outgoing message exactly when old and new values of that update pass the three tests against the soft limit. It is 0 on a stop message.
- R10: frame_start clears every frozen bit. All other inputs in that cycle are ignored, and msg_valid is 0 next cycle.
- R11: When a local update and a network message arrive in the same cycle, the local update is processed and the network message is dropped.
- R12: A new value equal to the stop code is saturated to -255 before it is stored or sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears all frozen bits |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | 0 selects hard threshold, 1 selects soft threshold |
| thr_frac | input | FRAC_W | Threshold fraction of the maximum magnitude, units of 2^-FRAC_W |
| upd_valid | input | 1 | Local LLR update present |
| upd_hard | input | 1 | Run the per-iteration freeze test on this update |
| upd_addr | input | AW | LLR index of the local update |
| upd_old | input | LLR_W | Pre-processing LLR value |
| upd_new | input | LLR_W | Post-processing LLR value |
| net_valid | input | 1 | Message from the network present |
| net_addr | input | AW | LLR index of the network message |
| net_data | input | LLR_W | Network message value or stop code |
| rd_addr | input | AW | Lookup index into the LLR store |
| rd_data | output | LLR_W | Stored LLR at rd_addr |
| rd_frozen | output | 1 | Frozen bit at rd_addr |
| msg_valid | output | 1 | Outgoing message present |
| msg_data | output | LLR_W | Outgoing LLR value or stop code |
| msg_expendable | output | 1 | Outgoing message may be dropped on collision |

## Verification
The freeze test is swept over a 31-by-31 grid of stored and new values that spans the whole data range in steps of 17. The grid covers every sign pairing, growing and shrinking magnitudes, and magnitudes on both sides of the hard and soft limits, so it separates each of the three tests and the two thresholds. Directed cases then sit exactly on each limit, use zero as the previous value, rewrite both thresholds, and repeat stop codes to tell first arrivals from repeats. Collision, frame-start and saturation patterns show which input wins and what the store holds afterwards.

// File: rtl/llr_freeze_pkg.sv
package llr_freeze_pkg;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_DATA = 2'd1,
    OUT_STOP = 2'd2
  } out_kind_t;

  function automatic int llr_mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit llr_same_sign(input int a, input int b);
    return (a < 0) == (b < 0);
  endfunction

  // Three-way reliability test: sign held, magnitude non-decreasing, above limit.
  function automatic bit llr_reliable(input int now_v, input int before_v, input int lim);
    return llr_same_sign(now_v, before_v)
        && (llr_mag(now_v) >= llr_mag(before_v))
        && (llr_mag(now_v) >= lim);
  endfunction

  function automatic int llr_scale_limit(input int frac, input int frac_w, input int max_mag);
    return (frac * max_mag) >>> frac_w;
  endfunction

endpackage

// File: rtl/llr_thr_regs.sv
module llr_thr_regs #(
  parameter int LLR_W    = 9,
  parameter int FRAC_W   = 8,
  parameter int HARD_DEF = 51,
  parameter int SOFT_DEF = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [FRAC_W-1:0] thr_frac,
  output logic [LLR_W-2:0]  hard_lim,
  output logic [LLR_W-2:0]  soft_lim
);
  import llr_freeze_pkg::*;

  localparam int MAGW    = LLR_W - 1;
  localparam int MAX_MAG = (1 << MAGW) - 1;
  localparam logic [MAGW-1:0] HARD_RST = MAGW'(llr_scale_limit(HARD_DEF, FRAC_W, MAX_MAG));
  localparam logic [MAGW-1:0] SOFT_RST = MAGW'(llr_scale_limit(SOFT_DEF, FRAC_W, MAX_MAG));

  logic [MAGW-1:0] lim_new;

  always_comb lim_new = MAGW'(llr_scale_limit(int'(thr_frac), FRAC_W, MAX_MAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_lim <= HARD_RST;
      soft_lim <= SOFT_RST;
    end else if (thr_we) begin
      if (thr_sel) soft_lim <= lim_new;
      else         hard_lim <= lim_new;
    end
  end

endmodule

// File: rtl/llr_store.sv
module llr_store #(
  parameter int LLR_W = 9,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_all,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic signed [LLR_W-1:0] wdata,
  input  logic                    flag_set,
  input  logic [AW-1:0]           flag_addr,
  input  logic [AW-1:0]           upd_addr,
  output logic signed [LLR_W-1:0] upd_word,
  output logic                    upd_flag,
  input  logic [AW-1:0]           net_addr,
  output logic                    net_flag,
  input  logic [AW-1:0]           rd_addr,
  output logic signed [LLR_W-1:0] rd_word,
  output logic                    rd_flag
);
  logic signed [LLR_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]        flags;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit_w, hit_f;
    always_comb begin
      hit_w = we && (waddr == AW'(g));
      hit_f = flag_set && (flag_addr == AW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     words[g] <= '0;
      else if (hit_w) words[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[g] <= 1'b0;
      else if (clear_all) flags[g] <= 1'b0;
      else if (hit_f)     flags[g] <= 1'b1;
    end
  end

  always_comb begin
    upd_word = words[upd_addr];
    upd_flag = flags[upd_addr];
    net_flag = flags[net_addr];
    rd_word  = words[rd_addr];
    rd_flag  = flags[rd_addr];
  end

endmodule

// File: rtl/llr_freeze_ctrl.sv
module llr_freeze_ctrl #(
  parameter int LLR_W = 9
) (
  input  logic                    frame_start,
  input  logic                    upd_valid,
  input  logic                    upd_hard,
  input  logic signed [LLR_W-1:0] upd_old,
  input  logic signed [LLR_W-1:0] upd_new_sat,
  input  logic signed [LLR_W-1:0] upd_prev,
  input  logic                    upd_frozen,
  input  logic                    net_valid,
  input  logic                    net_is_stop,
  input  logic                    net_frozen,
  input  logic [LLR_W-2:0]        hard_lim,
  input  logic [LLR_W-2:0]        soft_lim,
  output logic                    wr_en,
  output logic                    wr_from_net,
  output logic                    flag_set,
  output logic                    flag_from_net,
  output llr_freeze_pkg::out_kind_t out_kind,
  output logic                    out_exp,
  output logic                    ev_freeze,
  output logic                    ev_forward
);
  import llr_freeze_pkg::*;

  logic hard_ok, soft_ok;

  always_comb begin
    hard_ok = llr_reliable(int'(upd_new_sat), int'(upd_prev), int'(hard_lim));
    soft_ok = llr_reliable(int'(upd_new_sat), int'(upd_old), int'(soft_lim));
  end

  always_comb begin
    wr_en         = 1'b0;
    wr_from_net   = 1'b0;
    flag_set      = 1'b0;
    flag_from_net = 1'b0;
    out_kind      = OUT_NONE;
    out_exp       = 1'b0;
    ev_freeze     = 1'b0;
    ev_forward    = 1'b0;
    if (frame_start) begin
      // flags are cleared by the store; every other input is dropped
    end else if (upd_valid) begin
      if (!upd_frozen) begin
        wr_en = 1'b1;
        if (upd_hard && hard_ok) begin
          flag_set  = 1'b1;
          out_kind  = OUT_STOP;
          ev_freeze = 1'b1;
        end else begin
          out_kind = OUT_DATA;
          out_exp  = soft_ok;
        end
      end
    end else if (net_valid && !net_frozen) begin
      if (net_is_stop) begin
        flag_set      = 1'b1;
        flag_from_net = 1'b1;
        out_kind      = OUT_STOP;
        ev_forward    = 1'b1;
      end else begin
        wr_en       = 1'b1;
        wr_from_net = 1'b1;
      end
    end
  end

endmodule

// File: rtl/llr_freeze_unit.sv
module llr_freeze_unit #(
  parameter int LLR_W    = 9,
  parameter int FRAC_W   = 8,
  parameter int DEPTH    = 16,
  parameter int HARD_DEF = 51,
  parameter int SOFT_DEF = 26,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    thr_we,
  input  logic                    thr_sel,
  input  logic [FRAC_W-1:0]       thr_frac,
  input  logic                    upd_valid,
  input  logic                    upd_hard,
  input  logic [AW-1:0]           upd_addr,
  input  logic signed [LLR_W-1:0] upd_old,
  input  logic signed [LLR_W-1:0] upd_new,
  input  logic                    net_valid,
  input  logic [AW-1:0]           net_addr,
  input  logic signed [LLR_W-1:0] net_data,
  input  logic [AW-1:0]           rd_addr,
  output logic signed [LLR_W-1:0] rd_data,
  output logic                    rd_frozen,
  output logic                    msg_valid,
  output logic signed [LLR_W-1:0] msg_data,
  output logic                    msg_expendable
);
  import llr_freeze_pkg::*;

  localparam logic signed [LLR_W-1:0] STOP_CODE = {1'b1, {(LLR_W-1){1'b0}}};
  localparam logic signed [LLR_W-1:0] NEG_MAX   = STOP_CODE + 1'b1;

  logic [LLR_W-2:0]        hard_lim, soft_lim;
  logic signed [LLR_W-1:0] upd_new_sat, upd_prev, wr_data;
  logic                    upd_frozen, net_frozen, net_is_stop;
  logic                    wr_en, wr_from_net, flag_set, flag_from_net;
  logic [AW-1:0]           wr_addr, flag_addr;
  out_kind_t               out_kind;
  logic                    out_exp, ev_freeze, ev_forward;

  always_comb begin
    upd_new_sat = (upd_new == STOP_CODE) ? NEG_MAX : upd_new;
    net_is_stop = (net_data == STOP_CODE);
    wr_addr     = wr_from_net ? net_addr : upd_addr;
    wr_data     = wr_from_net ? net_data : upd_new_sat;
    flag_addr   = flag_from_net ? net_addr : upd_addr;
  end

  llr_thr_regs #(
    .LLR_W(LLR_W), .FRAC_W(FRAC_W), .HARD_DEF(HARD_DEF), .SOFT_DEF(SOFT_DEF)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_sel(thr_sel),
    .thr_frac(thr_frac), .hard_lim(hard_lim), .soft_lim(soft_lim)
  );

  llr_store #(.LLR_W(LLR_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_all(frame_start),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .flag_set(flag_set), .flag_addr(flag_addr),
    .upd_addr(upd_addr), .upd_word(upd_prev), .upd_flag(upd_frozen),
    .net_addr(net_addr), .net_flag(net_frozen),
    .rd_addr(rd_addr), .rd_word(rd_data), .rd_flag(rd_frozen)
  );

  llr_freeze_ctrl #(.LLR_W(LLR_W)) u_ctrl (
    .frame_start(frame_start), .upd_valid(upd_valid), .upd_hard(upd_hard),
    .upd_old(upd_old), .upd_new_sat(upd_new_sat), .upd_prev(upd_prev),
    .upd_frozen(upd_frozen), .net_valid(net_valid), .net_is_stop(net_is_stop),
    .net_frozen(net_frozen), .hard_lim(hard_lim), .soft_lim(soft_lim),
    .wr_en(wr_en), .wr_from_net(wr_from_net), .flag_set(flag_set),
    .flag_from_net(flag_from_net), .out_kind(out_kind), .out_exp(out_exp),
    .ev_freeze(ev_freeze), .ev_forward(ev_forward)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid      <= 1'b0;
      msg_data       <= '0;
      msg_expendable <= 1'b0;
    end else begin
      msg_valid      <= (out_kind != OUT_NONE);
      msg_expendable <= (out_kind == OUT_DATA) && out_exp;
      if (out_kind == OUT_STOP)      msg_data <= STOP_CODE;
      else if (out_kind == OUT_DATA) msg_data <= upd_new_sat;
    end
  end

endmodule

// File: rtl/llr_freeze_chk.sv
module llr_freeze_chk #(
  parameter int LLR_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_start,
  input logic                    upd_valid,
  input logic                    upd_hard,
  input logic                    net_valid,
  input logic signed [LLR_W-1:0] net_data,
  input logic                    upd_frozen,
  input logic                    net_frozen,
  input logic                    ev_freeze,
  input logic                    ev_forward,
  input logic                    msg_valid,
  input logic signed [LLR_W-1:0] msg_data,
  input logic                    msg_expendable
);
  localparam logic signed [LLR_W-1:0] STOP = {1'b1, {(LLR_W-1){1'b0}}};

  logic net_stop_only;
  always_comb net_stop_only = !frame_start && !upd_valid && net_valid && (net_data == STOP);

  a_r3_freeze_sends_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_freeze |=> (msg_valid && msg_data == STOP));

  a_r4_no_stop_without_check: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && upd_valid && !upd_hard && !upd_frozen) |=> (msg_valid && msg_data != STOP));

  a_r5_frozen_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && upd_valid && upd_frozen) |=> !msg_valid);

  a_r6_forward_first: assert property (@(posedge clk) disable iff (!rst_n)
    (net_stop_only && !net_frozen) |=> (msg_valid && msg_data == STOP));

  a_r7_no_reforward: assert property (@(posedge clk) disable iff (!rst_n)
    (net_stop_only && net_frozen) |=> !msg_valid);

  a_r9_stop_never_expendable: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_data == STOP) |-> !msg_expendable);

  a_r10_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !msg_valid);

  a_r11_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_forward |-> !upd_valid));

  a_r12_data_never_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_data == STOP) |-> $past(ev_freeze || ev_forward));

endmodule

bind llr_freeze_unit llr_freeze_chk #(.LLR_W(LLR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .upd_valid(upd_valid),
  .upd_hard(upd_hard), .net_valid(net_valid), .net_data(net_data),
  .upd_frozen(upd_frozen), .net_frozen(net_frozen), .ev_freeze(ev_freeze),
  .ev_forward(ev_forward), .msg_valid(msg_valid), .msg_data(msg_data),
  .msg_expendable(msg_expendable)
);

// File: tb/llr_freeze_unit_test.sv
module llr_freeze_unit_test;
  localparam int W = 9;
  localparam int FW = 8;
  localparam int D = 16;
  localparam int AW = 4;
  localparam int STOP = -256;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, thr_we = 0, thr_sel = 0;
  logic [FW-1:0] thr_frac = '0;
  logic upd_valid = 0, upd_hard = 0;
  logic [AW-1:0] upd_addr = '0, net_addr = '0, rd_addr = '0;
  logic signed [W-1:0] upd_old = '0, upd_new = '0, net_data = '0;
  logic net_valid = 0;
  logic signed [W-1:0] rd_data, msg_data;
  logic rd_frozen, msg_valid, msg_expendable;

  int checks = 0, failures = 0;
  bit done = 0;
  int hlim = 50, slim = 25;

  always #10 clk = ~clk;

  llr_freeze_unit uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .thr_we(thr_we),
    .thr_sel(thr_sel), .thr_frac(thr_frac), .upd_valid(upd_valid),
    .upd_hard(upd_hard), .upd_addr(upd_addr), .upd_old(upd_old),
    .upd_new(upd_new), .net_valid(net_valid), .net_addr(net_addr),
    .net_data(net_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_frozen(rd_frozen), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_expendable(msg_expendable)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absv(input int v); return v < 0 ? -v : v; endfunction
  function automatic bit model_ok(input int n, input int p, input int lim);
    return ((n >= 0) == (p >= 0)) && absv(n) >= absv(p) && absv(n) >= lim;
  endfunction

  task automatic clear_inputs;
    frame_start = 0; thr_we = 0; upd_valid = 0; upd_hard = 0; net_valid = 0;
  endtask

  // inputs set here, registered output visible at the following negedge
  task automatic step;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic frame;
    frame_start = 1; step();
  endtask

  task automatic net_send(input int a, input int v);
    net_valid = 1; net_addr = AW'(a); net_data = W'(v); step();
  endtask

  task automatic upd_send(input int a, input int o, input int n, input bit h);
    upd_valid = 1; upd_addr = AW'(a); upd_old = W'(o); upd_new = W'(n); upd_hard = h; step();
  endtask

  task automatic peek(input int a);
    rd_addr = AW'(a); #1;
  endtask

  task automatic thr_write(input bit sel, input int f);
    thr_we = 1; thr_sel = sel; thr_frac = FW'(f); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 msg_valid", int'(msg_valid), 0);
    for (int a = 0; a < D; a++) begin
      peek(a);
      check("R1 frozen", int'(rd_frozen), 0);
      check("R1 data", int'(rd_data), 0);
    end

    // R3 R4 R9 sweep with default limits (R2 defaults)
    for (int i = 0; i < 31; i++) begin
      for (int j = 0; j < 31; j++) begin
        int p, n, a;
        bit fz;
        p = -255 + 17 * i;
        n = -255 + 17 * j;
        a = (i + j) % D;
        frame();
        net_send(a, p);
        upd_send(a, p, n, 1'b1);
        fz = model_ok(n, p, hlim);
        check("R3 R4 valid", int'(msg_valid), 1);
        peek(a);
        check("R3 R4 store", int'(rd_data), n);
        if (fz) begin
          check("R3 stop code", int'(msg_data), STOP);
          check("R3 frozen", int'(rd_frozen), 1);
          check("R9 stop not expendable", int'(msg_expendable), 0);
        end else begin
          check("R4 data", int'(msg_data), n);
          check("R4 not frozen", int'(rd_frozen), 0);
          check("R9 expendable", int'(msg_expendable), int'(model_ok(n, p, slim)));
        end
      end
    end

    // R3 boundaries at the hard limit
    frame();
    net_send(1, 10); upd_send(1, 0, 50, 1);
    check("R3 at limit", int'(msg_data), STOP);
    net_send(2, 10); upd_send(2, 0, 49, 1);
    check("R3 below limit", int'(msg_data), 49);
    net_send(4, -10); upd_send(4, 0, -50, 1);
    check("R3 negative at limit", int'(msg_data), STOP);
    net_send(9, 0); upd_send(9, 0, 50, 1);
    check("R3 zero previous", int'(msg_data), STOP);
    net_send(10, -1); upd_send(10, 0, 60, 1);
    check("R3 sign change", int'(msg_data), 60);
    net_send(11, 60); upd_send(11, 0, 59, 1);
    check("R3 shrinking", int'(msg_data), 59);
    // R4 check disabled
    net_send(12, 10); upd_send(12, 0, 200, 0);
    check("R4 no check", int'(msg_data), 200);
    peek(12); check("R4 no check frozen", int'(rd_frozen), 0);

    // R5 frozen LLR 1 holds 50
    upd_send(1, 0, 120, 1);
    check("R5 silent", int'(msg_valid), 0);
    peek(1); check("R5 unchanged", int'(rd_data), 50);
    // R8 network data to frozen is ignored
    net_send(1, -7);
    check("R8 no msg", int'(msg_valid), 0);
    peek(1); check("R8 frozen ignored", int'(rd_data), 50);
    net_send(6, -33);
    check("R8 no msg write", int'(msg_valid), 0);
    peek(6); check("R8 write", int'(rd_data), -33);

    // R6 R7 network stop
    net_send(5, 7);
    net_send(5, STOP);
    check("R6 forward valid", int'(msg_valid), 1);
    check("R6 forward code", int'(msg_data), STOP);
    peek(5);
    check("R6 frozen", int'(rd_frozen), 1);
    check("R6 data kept", int'(rd_data), 7);
    net_send(5, STOP);
    check("R7 no reforward", int'(msg_valid), 0);

    // R10 frame start
    frame_start = 1; upd_valid = 1; upd_addr = 6; upd_new = 99; upd_hard = 0; step();
    check("R10 quiet", int'(msg_valid), 0);
    peek(6); check("R10 input ignored", int'(rd_data), -33);
    peek(1); check("R10 cleared", int'(rd_frozen), 0);
    peek(5); check("R10 cleared net", int'(rd_frozen), 0);

    // R11 collision
    net_send(8, 3);
    upd_valid = 1; upd_addr = 7; upd_old = 0; upd_new = 77; upd_hard = 0;
    net_valid = 1; net_addr = 8; net_data = 44; step();
    check("R11 local out", int'(msg_data), 77);
    peek(8); check("R11 net dropped", int'(rd_data), 3);

    // R12 saturation
    upd_send(13, 0, STOP, 0);
    check("R12 msg", int'(msg_data), -255);
    peek(13); check("R12 store", int'(rd_data), -255);

    // R2 threshold writes
    thr_write(0, 128); hlim = 127;
    frame();
    net_send(3, 0); upd_send(3, 0, 127, 1);
    check("R2 hard at new limit", int'(msg_data), STOP);
    net_send(14, 0); upd_send(14, 0, 126, 1);
    check("R2 hard below new limit", int'(msg_data), 126);
    thr_write(1, 255); slim = 254;
    upd_send(15, 0, 254, 0);
    check("R2 soft at new limit", int'(msg_expendable), 1);
    upd_send(15, 0, 253, 0);
    check("R2 soft below new limit", int'(msg_expendable), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule